// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous request source and an external asynchronous static RAM of 131,072 bytes. It accepts one read or one write at a time on a valid/ready handshake. Each request carries a direction bit, a 17-bit word address and an 8-bit write byte. The block then drives the memory's active-low chip-select, write-strobe and output-strobe pins, its address bus and its data bus. Read data comes back with a single-cycle valid pulse.

Every phase of an access lasts a whole number of system clocks, and each of those counts is a parameter. The user derives each count by rounding the memory's nanosecond minimum up to whole clocks of the chosen period. A count below one is raised to one.

The data bus has a separate driver-enable output for the pad's tri-state buffer. The sequencer keeps that driver off whenever the memory's own outputs could be active. When an access changes direction from the previous one, it first waits out an idle turnaround window.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and after its release, until a request is accepted: chip-select, write-strobe and output-strobe are high (1), the data driver enable is 0, ready is 1 and the response valid is 0.
- R2: A request is taken on a clock edge where valid and ready are both 1, and ready stays 0 while the access runs. Each access keeps ready low for a fixed number of clocks: a write for WR_SETUP_CYC + WR_PULSE_CYC + 1, a read for RD_ACCESS_CYC. A further TURN_CYC clocks are added when the direction differs from the previous accepted access. The first access after reset adds none.
- R3: Throughout a write, the write-strobe is low for exactly WR_PULSE_CYC consecutive clocks. Chip-select is low and the output-strobe high during that window. The data driver is enabled for WR_SETUP_CYC + WR_PULSE_CYC + 1 clocks, and address and data are held stable across all of them, including the clock after the write-strobe rises.
- R4: On the rising edge of the write-strobe the memory holds the request's full 17-bit address and byte, so a later read of that address returns that byte.
- R5: During a read, the output-strobe is low for exactly RD_ACCESS_CYC clocks, with chip-select low, the write-strobe high and the data driver off. The bus is sampled at the edge that ends the last such clock. The response valid is 1 for exactly the next clock, together with the sampled byte.
- R6: The data driver is never enabled while the output-strobe is low. At least TURN_CYC clocks separate the output-strobe rising and the driver turning on. At least TURN_CYC clocks separate the driver turning off and the output-strobe falling.
- R7: Whenever ready is 1, chip-select, write-strobe and output-strobe are high and the data driver is off (standby).
- R8: The response valid pulses once per accepted read and never for a write.
- R9: While ready is 0, the request fields (direction, address, write byte) are ignored. Changing them mid-access alters neither the memory's contents nor the data returned.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read byte valid, one clock |
| rsp_rdata | output | 8 | Read byte |
| sram_ce_n | output | 1 | Memory chip-select, active low |
| sram_we_n | output | 1 | Memory write-strobe, active low |
| sram_oe_n | output | 1 | Memory output-strobe, active low |
| sram_addr | output | 17 | Memory address bus |
| sram_dq_out | output | 8 | Byte toward the data pads |
| sram_dq_oe | output | 1 | Data pad driver enable, active high |
| sram_dq_in | input | 8 | Byte from the data pads |

## Verification
The properties assume that the clock period and the parameter counts together satisfy the memory's nanosecond minimums. They also assume that the source raises valid only with well-defined fields, and that the pad returns real data once the output-strobe has been low long enough.

The stimulus stays inside these assumptions. It uses a memory model that returns junk until the output-strobe has been low for two clocks, and it holds valid low while the sequencer is busy. It scrambles the request fields during each access, sweeping every word of a 64-word window with differing high address bits, first in long same-direction runs and then in alternating write/read pairs.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_WSET  = 3'd2,
    ST_WPUL  = 3'd3,
    ST_WHOLD = 3'd4,
    ST_RACC  = 3'd5
  } sram_state_e;

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] rdat_q;
  logic              rvld_q;

  // Request fields latched only on acceptance, so they hold for the whole access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (capture) begin
      rdat_q <= sram_dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= capture;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdat_q;
  assign rsp_rdata   = rdat_q;
  assign rsp_valid   = rvld_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned WR_SETUP_CYC  = 2,
  parameter int unsigned WR_PULSE_CYC  = 2,
  parameter int unsigned RD_ACCESS_CYC = 3,
  parameter int unsigned TURN_CYC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned WS_N  = at_least_one(WR_SETUP_CYC);
  localparam int unsigned WP_N  = at_least_one(WR_PULSE_CYC);
  localparam int unsigned RA_N  = at_least_one(RD_ACCESS_CYC);
  localparam int unsigned TA_N  = at_least_one(TURN_CYC);
  localparam int unsigned MAX_A = (WS_N > WP_N) ? WS_N : WP_N;
  localparam int unsigned MAX_B = (RA_N > TA_N) ? RA_N : TA_N;
  localparam int unsigned MAX_N = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = (MAX_N < 2) ? 1 : $clog2(MAX_N);

  sram_state_e      state_q, state_d;
  logic             dir_q, dir_d;
  logic             seen_q, seen_d;
  logic             accept;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             capture;
  logic             ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic             ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    seen_d  = seen_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          dir_d  = req_write;
          seen_d = 1'b1;
          if (seen_q && (dir_q != req_write)) begin
            state_d = ST_TURN;
          end else begin
            state_d = req_write ? ST_WSET : ST_RACC;
          end
        end
      end
      ST_TURN:  if (expired) state_d = dir_q ? ST_WSET : ST_RACC;
      ST_WSET:  if (expired) state_d = ST_WPUL;
      ST_WPUL:  if (expired) state_d = ST_WHOLD;
      ST_WHOLD: state_d = ST_IDLE;
      ST_RACC:  if (expired) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Timer reload on every state change with the new phase's length.
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_TURN: tmr_val = CNT_W'(TA_N - 1);
      ST_WSET: tmr_val = CNT_W'(WS_N - 1);
      ST_WPUL: tmr_val = CNT_W'(WP_N - 1);
      ST_RACC: tmr_val = CNT_W'(RA_N - 1);
      default: tmr_val = '0;
    endcase
  end

  // Pin levels decoded from the next state, then registered glitch-free.
  always_comb begin
    ce_n_d  = (state_d == ST_IDLE);
    we_n_d  = (state_d != ST_WPUL);
    oe_n_d  = (state_d != ST_RACC);
    dq_oe_d = (state_d == ST_WSET) || (state_d == ST_WPUL) || (state_d == ST_WHOLD);
  end

  assign capture = (state_q == ST_RACC) && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      seen_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      seen_q  <= seen_d;
      ce_n_q  <= ce_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign sram_ce_n  = ce_n_q;
  assign sram_we_n  = we_n_q;
  assign sram_oe_n  = oe_n_q;
  assign sram_dq_oe = dq_oe_q;

  sram_cycle_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_io_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_io (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .capture     (capture),
    .sram_dq_in  (sram_dq_in),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .rsp_rdata   (rsp_rdata),
    .rsp_valid   (rsp_valid)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned WR_PULSE_CYC  = 2,
  parameter int unsigned RD_ACCESS_CYC = 3,
  parameter int unsigned TURN_CYC      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_out
);

  localparam int unsigned WP_N = (WR_PULSE_CYC < 1) ? 1 : WR_PULSE_CYC;
  localparam int unsigned RA_N = (RD_ACCESS_CYC < 1) ? 1 : RD_ACCESS_CYC;
  localparam int unsigned TA_N = (TURN_CYC < 1) ? 1 : TURN_CYC;
  localparam int unsigned CW   = $clog2(WP_N + RA_N + TA_N + 2);

  logic [CW-1:0] we_lo_cnt, oe_lo_cnt, drv_off_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt   <= '0;
      oe_lo_cnt   <= '0;
      drv_off_cnt <= CW'(TA_N);
      oe_hi_cnt   <= CW'(TA_N);
    end else begin
      we_lo_cnt   <= sram_we_n ? '0 : we_lo_cnt + CW'(1);
      oe_lo_cnt   <= sram_oe_n ? '0 : oe_lo_cnt + CW'(1);
      if (sram_dq_oe) drv_off_cnt <= '0;
      else if (drv_off_cnt < CW'(TA_N)) drv_off_cnt <= drv_off_cnt + CW'(1);
      if (!sram_oe_n) oe_hi_cnt <= '0;
      else if (oe_hi_cnt < CW'(TA_N)) oe_hi_cnt <= oe_hi_cnt + CW'(1);
    end
  end

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_we_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe && !sram_ce_n && sram_oe_n);

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_cnt == CW'(WP_N)) && sram_dq_oe);

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe && $past(sram_dq_oe) |-> $stable(sram_addr) && $stable(sram_dq_out));

  p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_lo_cnt == CW'(RA_N)));

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  p_turn_before_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_oe_n) |-> drv_off_cnt >= CW'(TA_N));

  p_turn_before_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> oe_hi_cnt >= CW'(TA_N));

  p_standby_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe);

  p_rsp_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .WR_PULSE_CYC  (WR_PULSE_CYC),
  .RD_ACCESS_CYC (RD_ACCESS_CYC),
  .TURN_CYC      (TURN_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .sram_ce_n   (sram_ce_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_dq_oe  (sram_dq_oe),
  .sram_addr   (sram_addr),
  .sram_dq_out (sram_dq_out)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int WS = 2;
  localparam int WP = 2;
  localparam int RA = 3;
  localparam int TA = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_dq_out, sram_dq_in;

  int checks = 0;
  int failures = 0;
  int reads_done = 0;
  int rsp_pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .WR_SETUP_CYC(WS), .WR_PULSE_CYC(WP),
    .RD_ACCESS_CYC(RA), .TURN_CYC(TA)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // Memory model: 64-word window tagged with the upper address bits.
  logic [DW-1:0] mem [64];
  logic [10:0]   tag [64];
  logic [2:0]    oe_age;

  always @(posedge sram_we_n) begin
    if (!sram_ce_n) begin
      mem[sram_addr[5:0]] = sram_dq_out;
      tag[sram_addr[5:0]] = sram_addr[16:6];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_age <= 3'd0;
    else if (!sram_oe_n && !sram_ce_n) oe_age <= (oe_age == 3'd7) ? 3'd7 : oe_age + 3'd1;
    else oe_age <= 3'd0;
  end

  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n && oe_age >= 3'd2) ?
                      ((tag[sram_addr[5:0]] == sram_addr[16:6]) ? mem[sram_addr[5:0]] : 8'hEE) :
                      8'h5A;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bus-discipline monitor (R5, R6).
  int  oe_hi_run = 100;
  int  drv_off_run = 100;
  bit  prev_dq_oe = 1'b0;
  bit  prev_oe_n = 1'b1;
  bit  prev_rsp = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_dq_oe && !sram_oe_n) check(1'b0, "R6 contention", 1, 0);
      if (sram_dq_oe && !prev_dq_oe) check(oe_hi_run >= TA, "R6 gap before drive", oe_hi_run, TA);
      if (!sram_oe_n && prev_oe_n) check(drv_off_run >= TA, "R6 gap before read", drv_off_run, TA);
      if (rsp_valid && prev_rsp) check(1'b0, "R5 pulse width", 2, 1);
      if (rsp_valid) rsp_pulses++;
      oe_hi_run   = sram_oe_n ? oe_hi_run + 1 : 0;
      drv_off_run = sram_dq_oe ? 0 : drv_off_run + 1;
      prev_dq_oe  = sram_dq_oe;
      prev_oe_n   = sram_oe_n;
      prev_rsp    = rsp_valid;
    end
  end

  logic [DW-1:0] exp_d  [64];
  logic [10:0]   exp_hi [64];
  bit have_prev = 1'b0;
  bit prev_wr   = 1'b0;

  task automatic access(input bit wr, input int idx, input int rnd);
    logic [10:0] hi;
    logic [DW-1:0] d;
    int busy, welo, oelo, drv, exp_busy;
    hi = wr ? 11'((idx * 37 + rnd * 5 + 1) & 11'h7FF) : exp_hi[idx];
    d  = 8'((idx * 29 + rnd * 101 + 7) & 8'hFF);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {hi, 6'(idx)};
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; welo = 0; oelo = 0; drv = 0;
    while (!req_ready) begin
      busy++;
      if (!sram_we_n) welo++;
      if (!sram_oe_n) oelo++;
      if (sram_dq_oe) drv++;
      // R9: scramble fields while busy.
      req_write = ~req_write;
      req_addr  = req_addr ^ 17'h15A3C;
      req_wdata = ~req_wdata + 8'(busy);
      @(negedge clk);
    end
    exp_busy = wr ? (WS + WP + 1) : RA;
    if (have_prev && (prev_wr != wr)) exp_busy += TA;
    check(busy == exp_busy, "R2 busy length", busy, exp_busy);
    check(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R7 standby pins",
          {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    if (wr) begin
      check(welo == WP, "R3 write strobe width", welo, WP);
      check(drv == WS + WP + 1, "R3 driver window", drv, WS + WP + 1);
      check(!rsp_valid, "R8 no response on write", rsp_valid, 0);
      exp_d[idx]  = d;
      exp_hi[idx] = hi;
    end else begin
      reads_done++;
      check(oelo == RA, "R5 output strobe width", oelo, RA);
      check(rsp_valid, "R5 response valid", rsp_valid, 1);
      check(rsp_rdata == exp_d[idx], "R4 R9 read data", rsp_rdata, exp_d[idx]);
    end
    have_prev = 1'b1;
    prev_wr   = wr;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'h00;
      tag[i] = 11'h7FF;
    end
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready && !rsp_valid,
          "R1 reset pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready && !rsp_valid,
          "R1 after release", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rsp_valid}, 6'b111010);
    // Same-direction runs.
    for (int i = 0; i < 64; i++) access(1'b1, i, 0);
    for (int i = 63; i >= 0; i--) access(1'b0, i, 0);
    // Alternating directions, each step turning the bus around.
    for (int i = 0; i < 64; i++) begin
      access(1'b1, i, 1);
      access(1'b0, (i * 11) & 63, 1);
    end
    for (int i = 0; i < 64; i++) access(1'b0, (i * 5 + 3) & 63, 2);
    repeat (3) @(negedge clk);
    check(rsp_pulses == reads_done, "R8 response count", rsp_pulses, reads_done);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule